// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block sits next to a stream-to-memory DMA channel and decides when the channel's one interrupt line to the processor goes high. It receives single-cycle event pulses from the channel: descriptor done, end of packet and error. It also receives control fields from the register file: one enable per source, a coalescing threshold, an idle-delay timeout, and write-one-to-clear acknowledge pulses. It drives a level interrupt, three sticky status flags and the number of descriptor-done events still needed before the next completion interrupt.

Completion interrupts are coalesced. The flag is raised only when the programmed number of descriptor-done events has been seen. Traffic can stop before that number is reached, so an idle-delay timer runs after every end-of-packet pulse. The timer raises the delay flag once a programmed number of prescaled ticks passes with no further end of packet. An error pulse raises the error flag at once. From then on, completion counting and the delay timer are frozen until software clears the error flag. All ports are plain control and status signals. No data passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After reset, `flag_done`, `flag_delay`, `flag_err` and `irq` are 0 and `count_left` is 1.
- R2: A `done_pulse` in a cycle with no reload and with `flag_err` low decrements `count_left` by one. If `count_left` is 1 at that pulse, `flag_done` is 1 on the next cycle and `count_left` is reloaded with the effective threshold.
- R3: A `thresh_wr` or `ack_done` pulse loads `count_left` with the effective threshold on the next cycle. This reload takes priority over a `done_pulse` in the same cycle, and that pulse is not counted.
- R4: The effective threshold is `thresh_val`, except that a `thresh_val` of 0 is treated as 1.
- R5: A prescaler runs freely from reset and produces a tick every PRESCALE cycles. An `eop_pulse` clears the idle timer and arms it. Each tick advances the armed timer by one. On the tick that brings it to `delay_val`, `flag_delay` is set and the timer is disarmed.
- R6: Each `eop_pulse` restarts the idle timer from zero. While `delay_val` is 0 the timer is held at zero and disarmed, and `flag_delay` is never set.
- R7: An `err_pulse` sets `flag_err` on the next cycle, whatever the threshold. While `flag_err` is 1, `done_pulse` and `eop_pulse` have no effect, `count_left` holds its value and the idle timer is frozen.
- R8: Each flag stays set until its acknowledge pulse (`ack_done`, `ack_delay`, `ack_err`) clears it. If a set and its acknowledge fall in the same cycle for the delay or error flag, the set wins.
- R9: `irq` is high exactly when some flag is 1 and its enable (`en_done`, `en_delay`, `en_err`) is 1. A disabled source still sets its flag but does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_pulse | input | 1 | Descriptor completed (one cycle) |
| eop_pulse | input | 1 | End of packet seen (one cycle) |
| err_pulse | input | 1 | Channel error (one cycle) |
| en_done | input | 1 | Completion interrupt enable |
| en_delay | input | 1 | Idle-delay interrupt enable |
| en_err | input | 1 | Error interrupt enable |
| thresh_val | input | THRESH_W | Coalescing threshold |
| thresh_wr | input | 1 | Pulse: new threshold written |
| delay_val | input | DELAY_W | Idle timeout in prescaled ticks, 0 = off |
| ack_done | input | 1 | Write-one-to-clear for completion flag |
| ack_delay | input | 1 | Write-one-to-clear for delay flag |
| ack_err | input | 1 | Write-one-to-clear for error flag |
| irq | output | 1 | Level interrupt to processor |
| flag_done | output | 1 | Completion flag (sticky) |
| flag_delay | output | 1 | Idle-delay flag (sticky) |
| flag_err | output | 1 | Error flag (sticky) |
| count_left | output | THRESH_W | Completions still needed for the next flag |

## Verification
The in-RTL assertions check several rules on every cycle: `count_left` never reaches zero, the counter and idle timer stay frozen while the error flag is set, the timer is zeroed while the delay field is 0, an error pulse always sets its flag, the completion flag holds until acknowledged and rises only after a counted event, and `irq` stays low when every source is disabled. Some behaviour can only be shown by the bench scenarios. These include the exact cycle on which a threshold is reached, the dropping of a done pulse that collides with a reload, a threshold of zero acting as one, the delay flag's timing against the prescaled ticks, restarts by repeated end-of-packet pulses, and the set-over-acknowledge priority. The bench's behavioural model is compared against all outputs every cycle, and the scenarios cover each of these cases.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef struct packed {
    logic done;
    logic delay;
    logic err;
  } irq_flags_t;
endpackage

// File: rtl/irq_coalesce_counter.sv
module irq_coalesce_counter #(
  parameter int THRESH_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_pulse,
  input  logic                hold,
  input  logic                reload,
  input  logic [THRESH_W-1:0] thresh_val,
  output logic                reached,
  output logic [THRESH_W-1:0] count_left
);
  logic [THRESH_W-1:0] eff_thresh;
  logic [THRESH_W-1:0] cnt_q;

  assign eff_thresh = (thresh_val == '0) ? THRESH_W'(1) : thresh_val;
  assign reached    = done_pulse && !hold && !reload && (cnt_q == THRESH_W'(1));
  assign count_left = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= THRESH_W'(1);
    end else if (reload) begin
      cnt_q <= eff_thresh;
    end else if (done_pulse && !hold) begin
      if (cnt_q == THRESH_W'(1)) cnt_q <= eff_thresh;
      else                       cnt_q <= cnt_q - THRESH_W'(1);
    end
  end

  // R2: the outstanding count never sits at zero
  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  // R7: counting frozen while halted by an error
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_idle_timer.sv
module irq_idle_timer #(
  parameter int DELAY_W  = 8,
  parameter int PRESCALE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eop_pulse,
  input  logic               hold,
  input  logic [DELAY_W-1:0] delay_val,
  output logic               expire
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic               tick;
  logic [DELAY_W-1:0] tmr_q;
  logic               armed_q;
  logic               last_step;

  generate
    if (PRESCALE > 1) begin : g_prescale
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PW'(1);
      end
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  assign last_step = ({1'b0, tmr_q} + (DELAY_W+1)'(1)) == {1'b0, delay_val};
  assign expire    = (delay_val != '0) && !hold && !eop_pulse && tick && armed_q && last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      armed_q <= 1'b0;
    end else if (delay_val == '0) begin
      tmr_q   <= '0;
      armed_q <= 1'b0;
    end else if (hold) begin
      tmr_q   <= tmr_q;
      armed_q <= armed_q;
    end else if (eop_pulse) begin
      tmr_q   <= '0;
      armed_q <= 1'b1;
    end else if (tick && armed_q) begin
      if (last_step) begin
        tmr_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        tmr_q <= tmr_q + DELAY_W'(1);
      end
    end
  end

  // R6: a zero delay field keeps the timer cleared and disarmed
  a_r6_off_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_val == '0) |=> (tmr_q == '0 && !armed_q));
  // R7: timer frozen while halted by an error
  a_r7_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && delay_val != '0) |=> ($stable(tmr_q) && $stable(armed_q)));
endmodule

// File: rtl/irq_status_flags.sv
module irq_status_flags
  import dma_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done,
  input  logic       set_delay,
  input  logic       set_err,
  input  logic       ack_done,
  input  logic       ack_delay,
  input  logic       ack_err,
  output irq_flags_t flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      if (set_done)       flags.done <= 1'b1;
      else if (ack_done)  flags.done <= 1'b0;
      if (set_delay)      flags.delay <= 1'b1;
      else if (ack_delay) flags.delay <= 1'b0;
      if (set_err)        flags.err <= 1'b1;
      else if (ack_err)   flags.err <= 1'b0;
    end
  end

  // R7: an error pulse always lands in the flag
  a_r7_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> flags.err);
  // R8: completion flag sticky until acknowledged
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.done && !ack_done) |=> flags.done);
  // R2: completion flag only rises after a counted event
  a_r2_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.done) |-> $past(set_done));
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
  import dma_irq_pkg::*;
#(
  parameter int THRESH_W = 8,
  parameter int DELAY_W  = 8,
  parameter int PRESCALE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_pulse,
  input  logic                eop_pulse,
  input  logic                err_pulse,
  input  logic                en_done,
  input  logic                en_delay,
  input  logic                en_err,
  input  logic [THRESH_W-1:0] thresh_val,
  input  logic                thresh_wr,
  input  logic [DELAY_W-1:0]  delay_val,
  input  logic                ack_done,
  input  logic                ack_delay,
  input  logic                ack_err,
  output logic                irq,
  output logic                flag_done,
  output logic                flag_delay,
  output logic                flag_err,
  output logic [THRESH_W-1:0] count_left
);
  irq_flags_t flags;
  logic       halted;
  logic       reached;
  logic       expire;

  assign halted = flags.err;

  irq_coalesce_counter #(.THRESH_W(THRESH_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_pulse (done_pulse),
    .hold       (halted),
    .reload     (thresh_wr || ack_done),
    .thresh_val (thresh_val),
    .reached    (reached),
    .count_left (count_left)
  );

  irq_idle_timer #(.DELAY_W(DELAY_W), .PRESCALE(PRESCALE)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .eop_pulse (eop_pulse),
    .hold      (halted),
    .delay_val (delay_val),
    .expire    (expire)
  );

  irq_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_done  (reached),
    .set_delay (expire),
    .set_err   (err_pulse),
    .ack_done  (ack_done),
    .ack_delay (ack_delay),
    .ack_err   (ack_err),
    .flags     (flags)
  );

  assign flag_done  = flags.done;
  assign flag_delay = flags.delay;
  assign flag_err   = flags.err;
  assign irq = (flags.done && en_done) || (flags.delay && en_delay) || (flags.err && en_err);

  // R9: with every source masked the line stays low
  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_done && !en_delay && !en_err) |-> !irq);
endmodule

// File: tb/test_dma_irq_coalescer.sv
module test_dma_irq_coalescer;
  localparam int TW = 8;
  localparam int DW = 8;
  localparam int PS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_pulse = 0, eop_pulse = 0, err_pulse = 0;
  logic en_done = 0, en_delay = 0, en_err = 0;
  logic [TW-1:0] thresh_val = 0;
  logic thresh_wr = 0;
  logic [DW-1:0] delay_val = 0;
  logic ack_done = 0, ack_delay = 0, ack_err = 0;
  logic irq, flag_done, flag_delay, flag_err;
  logic [TW-1:0] count_left;

  always #5 clk = ~clk;

  dma_irq_coalescer #(.THRESH_W(TW), .DELAY_W(DW), .PRESCALE(PS)) i_dma_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .eop_pulse(eop_pulse),
    .err_pulse(err_pulse), .en_done(en_done), .en_delay(en_delay), .en_err(en_err),
    .thresh_val(thresh_val), .thresh_wr(thresh_wr), .delay_val(delay_val),
    .ack_done(ack_done), .ack_delay(ack_delay), .ack_err(ack_err),
    .irq(irq), .flag_done(flag_done), .flag_delay(flag_delay), .flag_err(flag_err),
    .count_left(count_left)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cnt = 1, m_pre = 0, m_tmr = 0;
  bit m_armed = 0, m_fd = 0, m_fy = 0, m_fe = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 1; m_pre = 0; m_tmr = 0; m_armed = 0; m_fd = 0; m_fy = 0; m_fe = 0;
    end else begin
      bit halted, tick, setd, sety;
      int eff;
      halted = m_fe;
      eff = (thresh_val == 0) ? 1 : int'(thresh_val);
      tick = (m_pre == PS - 1);
      m_pre = tick ? 0 : m_pre + 1;
      setd = 0; sety = 0;
      if (thresh_wr || ack_done) m_cnt = eff;
      else if (done_pulse && !halted) begin
        if (m_cnt == 1) begin m_cnt = eff; setd = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (delay_val == 0) begin m_tmr = 0; m_armed = 0; end
      else if (halted) begin end
      else if (eop_pulse) begin m_tmr = 0; m_armed = 1; end
      else if (tick && m_armed) begin
        if (m_tmr + 1 == int'(delay_val)) begin m_tmr = 0; m_armed = 0; sety = 1; end
        else m_tmr = m_tmr + 1;
      end
      if (setd) m_fd = 1; else if (ack_done) m_fd = 0;
      if (sety) m_fy = 1; else if (ack_delay) m_fy = 0;
      if (err_pulse) m_fe = 1; else if (ack_err) m_fe = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 count_left", int'(count_left), m_cnt);
      chk("R2 flag_done", int'(flag_done), int'(m_fd));
      chk("R5 flag_delay", int'(flag_delay), int'(m_fy));
      chk("R7 flag_err", int'(flag_err), int'(m_fe));
      chk("R9 irq", int'(irq),
          int'((m_fd && en_done) || (m_fy && en_delay) || (m_fe && en_err)));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset count", int'(count_left), 1);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset flags", int'({flag_done, flag_delay, flag_err}), 0);

    en_done = 1; en_delay = 1; en_err = 1;
    thresh_val = 3; pulse(thresh_wr);
    chk("R3 load on write", int'(count_left), 3);
    pulse(done_pulse); pulse(done_pulse);
    chk("R2 two left done=0", int'(flag_done), 0);
    pulse(done_pulse);
    chk("R2 threshold reached", int'(flag_done), 1);
    chk("R2 reload after hit", int'(count_left), 3);
    chk("R9 irq on completion", int'(irq), 1);
    pulse(done_pulse);
    chk("R8 sticky", int'(flag_done), 1);
    pulse(ack_done);
    chk("R8 cleared by ack", int'(flag_done), 0);
    chk("R3 ack reloads", int'(count_left), 3);

    // reload wins over simultaneous done
    pulse(done_pulse);
    done_pulse = 1; thresh_wr = 1; thresh_val = 5; step(1); done_pulse = 0; thresh_wr = 0;
    chk("R3 collision drops pulse", int'(count_left), 5);

    thresh_val = 0; pulse(thresh_wr);
    chk("R4 zero as one", int'(count_left), 1);
    pulse(done_pulse);
    chk("R4 one per event", int'(flag_done), 1);
    pulse(ack_done);

    // delay timer
    delay_val = 3;
    for (int k = 0; k < 6; k++) begin pulse(eop_pulse); step(4); end
    chk("R6 restarts hold off flag", int'(flag_delay), 0);
    step(20);
    chk("R5 idle expiry", int'(flag_delay), 1);
    en_delay = 0; step(1);
    chk("R9 masked delay", int'(irq), 0);
    pulse(ack_delay);
    chk("R8 ack delay", int'(flag_delay), 0);
    en_delay = 1;
    delay_val = 0; pulse(eop_pulse); step(40);
    chk("R6 zero delay off", int'(flag_delay), 0);

    // error halt
    thresh_val = 2; pulse(thresh_wr); delay_val = 2;
    pulse(err_pulse);
    chk("R7 err immediate", int'(flag_err), 1);
    pulse(done_pulse); pulse(done_pulse); pulse(eop_pulse); step(30);
    chk("R7 count frozen", int'(count_left), 2);
    chk("R7 no delay while halted", int'(flag_delay), 0);
    err_pulse = 1; ack_err = 1; step(1); err_pulse = 0; ack_err = 0;
    chk("R8 set beats ack", int'(flag_err), 1);
    pulse(ack_err);
    chk("R8 err cleared", int'(flag_err), 0);
    pulse(done_pulse);
    chk("R7 resumes counting", int'(count_left), 1);
    pulse(eop_pulse); step(20);
    chk("R5 delay after resume", int'(flag_delay), 1);
    en_done = 0; en_delay = 0; en_err = 0; step(1);
    chk("R9 all masked", int'(irq), 0);
    step(2);
    finish_run();
  end
endmodule